// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple request port on the host side and a four-bank single-data-rate SDRAM. After reset it holds the memory in a quiet state for a programmable number of cycles. It then precharges every bank and runs two auto-refresh cycles. Next it loads the base mode register, which sets single-beat bursts and the chosen read latency. Last it loads the extended mode register. Only after the extended load does it accept host traffic.

Each host request is one beat of read or write. The block serves it by activating the row and then issuing the column command with auto precharge. Read data comes back on a separate valid strobe once the CAS latency has passed. A free-running timer sets a refresh request at the rate the 64 ms retention budget allows. A pending refresh goes out before the next host request is accepted.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While `rst` is high, `sd_cke` is low, `sd_cs_n` is high, `req_ready` is low and `rd_valid` is low.
- R2: After reset the pins carry no command, with CKE high, for at least `T_INIT` cycles. The first command is then a PRECHARGE with address bit 10 high, which closes all banks.
- R3: The next two commands after that precharge are AUTO REFRESH. They come before any mode-register load. `req_ready` stays low and no ACTIVE, READ or WRITE appears until both mode-register loads are done.
- R4: The base mode register is loaded first, with bank code 00. Its value has bits 2:0 = 000 (single beat), bit 3 = 0, bits 6:4 = CAS latency and bits 8:7 = 00. The extended register is loaded next, with bank code 10 and value `EMR_VAL`. Bank codes 01 and 11 never appear with a load.
- R5: Commands on {cs_n, ras_n, cas_n, we_n} use these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. No other code is driven while CS# is low.
- R6: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_addr` is split as {bank[1:0], row[ROW_W-1:0], col}. The column is 9 bits for a 16-bit data width and 8 bits for 32. The block issues ACTIVE to an idle bank. `T_RCD` cycles later it issues READ or WRITE with the column in the low address bits and bit 10 high. The next command follows no sooner than `CAS_LAT+T_RP` cycles after a READ, or `T_WR+T_RP` cycles after a WRITE.
- R7: If a READ is on the pins in cycle n, `rd_valid` pulses in cycle n+CAS_LAT+1. In that cycle `rd_data` holds what the memory drove CAS_LAT cycles after it registered the READ. Results come back in request order.
- R8: In the cycle of a WRITE, `sd_dq_out` carries the request data, `sd_dq_oe` is high and `sd_dqm` is low. `sd_dq_oe` is low in every other cycle.
- R9: The refresh interval is 64 ms times the clock rate divided by 2^ROW_W rows. Auto refreshes after initialization are spaced by that interval, within the length of one access. Each refresh is issued with all banks idle. A pending refresh is served before a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | DQ_W | Write data |
| req_ready | output | 1 | Request accepted on this edge if valid |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DQ_W | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ROW_W | Row / column / mode address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | DQ_W | Data driven to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DQ_W | Data from memory |

## Verification
The bench puts a memory model on the pins. The model stores written data and returns read data with the programmed latency. If the read latency were off by one, it would sample a wrong value and the strobe would fall in the wrong cycle. The bench checks the init order, the mode values and the bank codes; a swapped or reordered mode load shows up there. It also checks spacing between commands: if a gap were miscounted, ACTIVE would reach a bank still precharging or a refresh would come too soon. Refresh spacing is measured while the host pushes back-to-back traffic, so refresh starved by requests shows up as a stretched interval. The random traffic mixes row and column extremes, unwritten locations, and immediate write-then-read to the same address.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int DQ_W    = 16,
  parameter int ROW_W   = 12,
  parameter int CLK_MHZ = 200,
  parameter int REF_MS  = 64,
  parameter int CAS_LAT = 2,
  parameter int T_INIT  = 40,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 12,
  parameter int T_MRD   = 2,
  parameter int T_RCD   = 3,
  parameter int T_WR    = 2,
  parameter logic [ROW_W-1:0] EMR_VAL = '0,
  localparam int COL_W  = (DQ_W == 32) ? 8 : 9,
  localparam int ADDR_W = 2 + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              sd_dqm,
  output logic [DQ_W-1:0]   sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_in
);

  localparam int REF_INT = (REF_MS * 1000 * CLK_MHZ) / (1 << ROW_W);
  localparam int REF_W   = $clog2(REF_INT + 1);
  localparam int CNT_W   = $clog2(T_INIT + T_RFC + T_RCD + T_RP + T_WR + T_MRD + CAS_LAT + 2);
  localparam logic [ROW_W-1:0] AP_BIT = ROW_W'(1 << 10);
  localparam logic [ROW_W-1:0] MR_VAL = ROW_W'(CAS_LAT) << 4;

  localparam logic [3:0] C_INH = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [2:0] {ST_PWR, ST_REF1, ST_REF2, ST_MRS, ST_EMRS, ST_IDLE, ST_RW} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [REF_W-1:0]  ref_cnt;
  logic              ref_pend;
  logic [3:0]        cmd_q;
  logic              wr_q;
  logic [COL_W-1:0]  col_q;
  logic [DQ_W-1:0]   wd_q;
  logic [CAS_LAT:0]  rd_pipe;

  wire ref_fire = (ref_cnt == REF_W'(REF_INT - 1));
  wire go       = (cnt == '0);
  wire issue_rd = go && (st == ST_RW) && !wr_q;

  assign req_ready = (st == ST_IDLE) && go && !ref_pend;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWR;
      cnt       <= CNT_W'(T_INIT);
      ref_cnt   <= '0;
      ref_pend  <= 1'b0;
      cmd_q     <= C_INH;
      sd_cke    <= 1'b0;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dqm    <= 1'b1;
      sd_dq_oe  <= 1'b0;
      sd_dq_out <= '0;
      wr_q      <= 1'b0;
      col_q     <= '0;
      wd_q      <= '0;
    end else begin
      sd_cke   <= 1'b1;
      cmd_q    <= C_NOP;
      sd_dq_oe <= 1'b0;
      ref_cnt  <= ref_fire ? '0 : ref_cnt + 1'b1;
      if (!go) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          ST_PWR: begin
            cmd_q   <= C_PRE;
            sd_addr <= AP_BIT;
            cnt     <= CNT_W'(T_RP - 1);
            st      <= ST_REF1;
          end
          ST_REF1: begin
            cmd_q <= C_REF;
            cnt   <= CNT_W'(T_RFC - 1);
            st    <= ST_REF2;
          end
          ST_REF2: begin
            cmd_q <= C_REF;
            cnt   <= CNT_W'(T_RFC - 1);
            st    <= ST_MRS;
          end
          ST_MRS: begin
            cmd_q   <= C_LMR;
            sd_ba   <= 2'b00;
            sd_addr <= MR_VAL;
            cnt     <= CNT_W'(T_MRD - 1);
            st      <= ST_EMRS;
          end
          ST_EMRS: begin
            cmd_q   <= C_LMR;
            sd_ba   <= 2'b10;
            sd_addr <= EMR_VAL;
            sd_dqm  <= 1'b0;
            cnt     <= CNT_W'(T_MRD - 1);
            st      <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd_q    <= C_REF;
              cnt      <= CNT_W'(T_RFC - 1);
              ref_pend <= 1'b0;
            end else if (req_valid) begin
              cmd_q   <= C_ACT;
              sd_ba   <= req_addr[ADDR_W-1 -: 2];
              sd_addr <= req_addr[COL_W +: ROW_W];
              wr_q    <= req_write;
              col_q   <= req_addr[COL_W-1:0];
              wd_q    <= req_wdata;
              cnt     <= CNT_W'(T_RCD - 1);
              st      <= ST_RW;
            end
          end
          ST_RW: begin
            cmd_q     <= wr_q ? C_WR : C_RD;
            sd_addr   <= AP_BIT | ROW_W'(col_q);
            sd_dq_oe  <= wr_q;
            sd_dq_out <= wd_q;
            cnt       <= wr_q ? CNT_W'(T_WR + T_RP - 1) : CNT_W'(CAS_LAT + T_RP - 1);
            st        <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
      if (ref_fire) ref_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pipe  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[CAS_LAT-1:0], issue_rd};
      rd_valid <= rd_pipe[CAS_LAT];
      if (rd_pipe[CAS_LAT]) rd_data <= sd_dq_in;
    end
  end

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int CAS_LAT = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       a10,
  input logic       dqm,
  input logic       dq_oe,
  input logic       rd_valid,
  input logic       req_ready
);

  wire [3:0] c      = {cs_n, ras_n, cas_n, we_n};
  wire       is_lmr = (c == 4'b0000);
  wire       is_rd  = (c == 4'b0101);
  wire       is_wr  = (c == 4'b0100);
  wire       is_act = (c == 4'b0011);
  wire       is_nop = (c == 4'b0111);

  assert_lmr_bank_R4: assert property (@(posedge clk) disable iff (rst)
    is_lmr |-> (ba == 2'b00 || ba == 2'b10));

  assert_col_ap_R6: assert property (@(posedge clk) disable iff (rst)
    (is_rd || is_wr) |-> a10);

  assert_act_gap_R6: assert property (@(posedge clk) disable iff (rst)
    is_act |=> is_nop);

  assert_wr_unmask_R8: assert property (@(posedge clk) disable iff (rst)
    is_wr |-> (!dqm && dq_oe));

  assert_oe_only_wr_R8: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> is_wr);

  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(is_rd, CAS_LAT + 1));

  assert_ready_cke_R3: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> cke);

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.CAS_LAT(CAS_LAT)) u_chk (
  .clk(clk), .rst(rst), .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
  .cas_n(sd_cas_n), .we_n(sd_we_n), .ba(sd_ba), .a10(sd_addr[10]),
  .dqm(sd_dqm), .dq_oe(sd_dq_oe), .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb;
  localparam int DQ_W = 16, ROW_W = 12, COL_W = 9, AW = 2 + ROW_W + COL_W;
  localparam int CL = 3, T_INIT = 40, T_RP = 3, T_RFC = 12, T_MRD = 2, T_RCD = 3, T_WR = 2;
  localparam logic [ROW_W-1:0] EMR = 12'h020;
  localparam int REF_INT = (64 * 1000 * 200) / 4096;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DQ_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  logic [DQ_W-1:0] rd_data, sd_dq_out, sd_dq_in;
  logic [1:0] sd_ba;
  logic [ROW_W-1:0] sd_addr;

  always #2.5 clk = ~clk;

  sdram_cmd_seq #(.DQ_W(DQ_W), .ROW_W(ROW_W), .CLK_MHZ(200), .REF_MS(64), .CAS_LAT(CL),
    .T_INIT(T_INIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_RCD(T_RCD), .T_WR(T_WR),
    .EMR_VAL(EMR)) u_dut (.*);

  int errors = 0, checks = 0, cyc = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DQ_W-1:0] dflt(input logic [AW-1:0] k);
    return DQ_W'(k ^ (k >> 7)) ^ 16'h5A3C;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory model and protocol observer
  logic [DQ_W-1:0] mem [logic [AW-1:0]];
  logic [DQ_W-1:0] shadow [logic [AW-1:0]];
  logic [DQ_W-1:0] exp_q [$];
  int rt_q [$];
  logic [DQ_W-1:0] rq_d [0:CL-1];
  logic [DQ_W-1:0] rd_val;
  logic [3:0] mc;
  logic [AW-1:0] key;
  int init_step = 0, nop_run = 0, last_cmd = 0, need_gap = 0, ref_seen = 0, last_ref = 0, now;
  string gap_tag = "R2";
  bit open_b [4];
  int act_cyc [4];
  logic [ROW_W-1:0] act_row [4];

  assign sd_dq_in = rq_d[CL-1];

  always @(posedge clk) begin
    rd_val = 16'h0BAD;
    if (!rst) begin
      now = cyc + 1;
      mc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (sd_dq_oe && mc != 4'b0100) chk(0, "R8 oe outside write", 32'(mc), 32'h4);
      if (sd_cs_n || mc == 4'b0111) begin
        if (init_step == 0 && sd_cke) nop_run++;
      end else begin
        chk(now - last_cmd >= need_gap, gap_tag, 32'(now - last_cmd), 32'(need_gap));
        last_cmd = now;
        if (init_step < 5) begin
          case (init_step)
            0: begin
              chk(nop_run >= T_INIT, "R2 power-up quiet cycles", 32'(nop_run), 32'(T_INIT));
              chk(mc == 4'b0010 && sd_addr[10], "R2 first cmd precharge-all", {mc, 16'(sd_addr)}, 32'h2_0400);
              need_gap = T_RP; gap_tag = "R3 gap after precharge";
            end
            1, 2: begin
              chk(mc == 4'b0001, "R3 auto refresh in init", 32'(mc), 32'h1);
              need_gap = T_RFC; gap_tag = "R3 gap after refresh";
            end
            3: begin
              chk(mc == 4'b0000 && sd_ba == 2'b00 && sd_addr == 12'(CL << 4), "R4 base mode load",
                  {mc, 2'(sd_ba), 16'(sd_addr)}, 32'(CL << 4));
              need_gap = T_MRD; gap_tag = "R4 gap after mode load";
            end
            default: begin
              chk(mc == 4'b0000 && sd_ba == 2'b10 && sd_addr == EMR, "R4 extended mode load",
                  {mc, 2'(sd_ba), 16'(sd_addr)}, {4'h0, 2'b10, 16'(EMR)});
              need_gap = T_MRD; gap_tag = "R4 gap after ext load";
            end
          endcase
          init_step++;
        end else begin
          case (mc)
            4'b0011: begin
              chk(!open_b[sd_ba], "R6 activate to idle bank", 32'(open_b[sd_ba]), 0);
              open_b[sd_ba] = 1; act_cyc[sd_ba] = now; act_row[sd_ba] = sd_addr;
              need_gap = T_RCD; gap_tag = "R6 row-to-column";
            end
            4'b0101, 4'b0100: begin
              chk(open_b[sd_ba] && sd_addr[10], "R6 column cmd with auto precharge",
                  {31'(open_b[sd_ba]), sd_addr[10]}, 32'h3);
              open_b[sd_ba] = 0;
              key = {sd_ba, act_row[sd_ba], sd_addr[COL_W-1:0]};
              if (mc == 4'b0100) begin
                chk(!sd_dqm && sd_dq_oe, "R8 write unmasked and driven", {sd_dqm, sd_dq_oe}, 32'h1);
                mem[key] = sd_dq_out;
                need_gap = T_WR + T_RP; gap_tag = "R6 gap after write";
              end else begin
                rd_val = mem.exists(key) ? mem[key] : dflt(key);
                rt_q.push_back(now);
                need_gap = CL + T_RP; gap_tag = "R6 gap after read";
              end
            end
            4'b0001: begin
              chk(!(open_b[0] || open_b[1] || open_b[2] || open_b[3]), "R9 refresh with banks idle", 1, 0);
              if (ref_seen > 0)
                chk(now - last_ref <= REF_INT + 40 && now - last_ref >= REF_INT - 40,
                    "R9 refresh interval", 32'(now - last_ref), 32'(REF_INT));
              ref_seen++; last_ref = now;
              need_gap = T_RFC; gap_tag = "R9 gap after refresh";
            end
            4'b0000: chk(0, "R4 mode load after init", 32'(sd_ba), 32'h0);
            4'b0010: chk(0, "R6 unexpected precharge", 32'(mc), 32'h5);
            default: chk(0, "R5 illegal command code", 32'(mc), 32'h7);
          endcase
        end
      end
    end
    rq_d[0] <= rd_val;
    for (int i = 1; i < CL; i++) rq_d[i] <= rq_d[i-1];
  end

  // read return monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (req_ready && init_step < 5) chk(0, "R3 ready before init done", 1, 0);
      if (rd_valid) begin
        if (exp_q.size() == 0 || rt_q.size() == 0) chk(0, "R7 unexpected read strobe", 1, 0);
        else begin
          automatic logic [DQ_W-1:0] e = exp_q.pop_front();
          automatic int t = rt_q.pop_front();
          chk(rd_data == e, "R7 read data", 32'(rd_data), 32'(e));
          chk(cyc == t + CL, "R7 read latency", 32'(cyc), 32'(t + CL));
        end
      end
    end
  end

  task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DQ_W-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (w) shadow[a] = d;
    else exp_q.push_back(shadow.exists(a) ? shadow[a] : dflt(a));
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    logic [ROW_W-1:0] r;
    logic [COL_W-1:0] c;
    case ($urandom % 4)
      0: r = '0;
      1: r = 12'd5;
      2: r = '1;
      default: r = ROW_W'($urandom);
    endcase
    c = COL_W'($urandom % 8) + (($urandom % 2) ? COL_W'(504) : '0);
    return {2'($urandom), r, c};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) begin
      @(negedge clk);
      chk(!sd_cke && sd_cs_n && !req_ready && !rd_valid, "R1 reset outputs",
          {sd_cke, sd_cs_n, req_ready, rd_valid}, 32'h4);
    end
    @(negedge clk); rst = 0;
    repeat (10) @(negedge clk);
    chk(!req_ready && sd_cke, "R3 no ready early in init", {req_ready, sd_cke}, 32'h1);
    while (init_step < 5) @(negedge clk);

    // directed corners
    do_req(1, {2'b11, 12'hFFF, 9'h1FF}, 16'hBEEF);
    do_req(0, {2'b11, 12'hFFF, 9'h1FF}, 16'h0);
    do_req(0, {2'b01, 12'h123, 9'h045}, 16'h0);
    do_req(1, {2'b00, 12'h000, 9'h000}, 16'h1234);
    do_req(1, {2'b00, 12'h000, 9'h000}, 16'hFFFF);
    do_req(0, {2'b00, 12'h000, 9'h000}, 16'h0);
    do_req(1, {2'b10, 12'h800, 9'h100}, 16'h0000);
    do_req(0, {2'b10, 12'h800, 9'h100}, 16'h0);

    for (int n = 0; n < 1500; n++)
      do_req(1'($urandom), rnd_addr(), 16'($urandom));

    while (cyc < 16000) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(ref_seen >= 4, "R9 refreshes after init", 32'(ref_seen), 32'd4);
    chk(exp_q.size() == 0, "R7 all reads returned", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule